// File: doc/BRIEF.md
# Authenticated Mode Exit Sequencer

This block carries out the clean-up work that ends a protected, authenticated code session. Once the fault checks elsewhere have accepted an exit, a single start pulse launches a fixed walk through six external operations, each a request/acknowledge exchange with an agent outside the block. The walk first wipes the private code RAM, then invalidates the address translation caches, then drains outgoing traffic. After that it sends three platform messages: close locality 3, lock the system-management memory, and release the processor. Afterwards the block rewrites the interrupt-pin mask, drops the authenticated mode flag and loads the program counter with the jump target captured at start.

The pin mask is rewritten according to how the session was opened. A session opened by the basic entry path gets all four pins (INIT, SMI, NMI, A20 gate) unmasked. A session opened by the measured launch path gets only INIT unmasked, plus SMI when bit 0 of the monitor control register is zero. An enter pulse, accepted only while idle, raises the authenticated mode flag and masks all four pins. Both the mode flag and the pin mask hold their values between operations. Pin events that arrive while masked stay pending outside the block and show on the pending output as soon as their mask bit clears.

The FSM states are IDLE, WIPE_RAM, FLUSH_TLB, DRAIN, MSG_CLOSE, MSG_LOCK, MSG_RELEASE, UNMASK and COMMIT. The transitions are IDLE to WIPE_RAM on start. Each step state moves to the next on an acknowledge, in the order listed, and MSG_RELEASE moves to UNMASK. UNMASK moves to COMMIT unconditionally, and COMMIT moves to IDLE unconditionally.

Top module: `acx_exit_seq`

## Requirements
- R1: After reset the block is idle: no request, busy low, done low, authenticated flag 0, program counter 0 and pin mask 0.
- R2: An enter pulse while idle sets the authenticated flag and sets all four mask bits (bit 0 INIT, bit 1 SMI, bit 2 NMI, bit 3 A20 gate). An enter pulse while busy has no effect.
- R3: A start pulse while idle asserts step_req_o in the next cycle. The step codes then run 0 (RAM wipe), 1 (TLB flush), 2 (drain), 3 (close locality 3), 4 (lock management memory), 5 (processor release), each exactly once in that order.
- R4: A request, with an unchanged code, stays high until step_ack_i is seen with it. The next code is requested in the cycle after the acknowledge. An acknowledge with no request pending has no effect.
- R5: The INIT mask bit is 0 after every exit.
- R6: After an exit whose measured flag was 0 at start, all four mask bits are 0.
- R7: After an exit whose measured flag was 1 at start, the NMI and A20 bits keep their values, and the SMI bit clears only if the monitor control bit was 0 at start.
- R8: The mask changes one cycle after the code-5 acknowledge. One cycle later the authenticated flag reads 0 and the program counter holds the target sampled at start.
- R9: done_o is a one-cycle pulse in the first idle cycle after an exit, the same cycle in which R8's flag and counter values first appear.
- R10: A start pulse while busy is ignored: the run in progress keeps its order and its captured target, measured flag and monitor bit.
- R11: pin_pend_o equals pin_evt_i with the masked bits removed, in every cycle, including the cycle in which a mask bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_i | input | 1 | Session opened: set flag, mask all pins |
| start_i | input | 1 | Accepted exit request, one-cycle pulse |
| target_i | input | ADDR_W | Checked jump target |
| measured_i | input | 1 | Session was opened by measured launch |
| mon_ctl0_i | input | 1 | Bit 0 of the monitor control register |
| step_ack_i | input | 1 | Acknowledge from the external agent |
| pin_evt_i | input | 4 | Pending pin events from outside |
| step_req_o | output | 1 | Step request |
| step_op_o | output | 3 | Step code (0 to 5) |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | Exit complete pulse |
| pin_mask_o | output | 4 | Pin mask, 1 = masked |
| pin_pend_o | output | 4 | Unmasked pending events |
| auth_mode_o | output | 1 | Authenticated mode flag |
| pc_o | output | ADDR_W | Program counter |

## Verification
The hardest case to reach is a second start pulse that arrives mid-walk with a different target and different entry flags, while acknowledges arrive irregularly. The stimulus fires that pulse during a slow acknowledge pattern, so the ignored request lands while a step is waiting. The three mask outcomes come from separate exits: basic entry, and measured entry with the monitor bit both clear and set. Pin events are held high across these exits, so the pending output is compared on the exact cycle each bit clears.

// File: rtl/acx_pkg.sv
package acx_pkg;

    localparam int NUM_PINS  = 4;
    localparam int OP_W      = 3;
    localparam int NUM_STEPS = 6;

    localparam int PIN_INIT = 0;
    localparam int PIN_SMI  = 1;
    localparam int PIN_NMI  = 2;
    localparam int PIN_A20  = 3;

    localparam logic [OP_W-1:0] OP_WIPE_RAM  = 3'd0;
    localparam logic [OP_W-1:0] OP_FLUSH_TLB = 3'd1;
    localparam logic [OP_W-1:0] OP_DRAIN     = 3'd2;
    localparam logic [OP_W-1:0] OP_CLOSE     = 3'd3;
    localparam logic [OP_W-1:0] OP_LOCK      = 3'd4;
    localparam logic [OP_W-1:0] OP_RELEASE   = 3'd5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WIPE_RAM,
        ST_FLUSH_TLB,
        ST_DRAIN,
        ST_MSG_CLOSE,
        ST_MSG_LOCK,
        ST_MSG_RELEASE,
        ST_UNMASK,
        ST_COMMIT
    } seq_state_t;

endpackage

// File: rtl/acx_seq_fsm.sv
module acx_seq_fsm
    import acx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            ack_i,
    output logic            req_o,
    output logic [OP_W-1:0] op_o,
    output logic            busy_o,
    output logic            accept_o,
    output logic            unmask_o,
    output logic            commit_o,
    output logic            done_o
);

    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start_i) state_d = ST_WIPE_RAM;
            ST_WIPE_RAM:    if (ack_i)   state_d = ST_FLUSH_TLB;
            ST_FLUSH_TLB:   if (ack_i)   state_d = ST_DRAIN;
            ST_DRAIN:       if (ack_i)   state_d = ST_MSG_CLOSE;
            ST_MSG_CLOSE:   if (ack_i)   state_d = ST_MSG_LOCK;
            ST_MSG_LOCK:    if (ack_i)   state_d = ST_MSG_RELEASE;
            ST_MSG_RELEASE: if (ack_i)   state_d = ST_UNMASK;
            ST_UNMASK:                   state_d = ST_COMMIT;
            ST_COMMIT:                   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_o    = 1'b0;
        op_o     = OP_WIPE_RAM;
        unmask_o = 1'b0;
        commit_o = 1'b0;
        accept_o = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_WIPE_RAM:    begin req_o = 1'b1; op_o = OP_WIPE_RAM;  end
            ST_FLUSH_TLB:   begin req_o = 1'b1; op_o = OP_FLUSH_TLB; end
            ST_DRAIN:       begin req_o = 1'b1; op_o = OP_DRAIN;     end
            ST_MSG_CLOSE:   begin req_o = 1'b1; op_o = OP_CLOSE;     end
            ST_MSG_LOCK:    begin req_o = 1'b1; op_o = OP_LOCK;      end
            ST_MSG_RELEASE: begin req_o = 1'b1; op_o = OP_RELEASE;   end
            ST_UNMASK:      unmask_o = 1'b1;
            ST_COMMIT:      commit_o = 1'b1;
            default:        busy_o   = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (state_q == ST_COMMIT);
    end

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && op_o == $past(op_o))); // R4

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && op_o != OP_RELEASE) |=> (req_o && op_o == 3'($past(op_o) + 3'd1))); // R3

    AST_LAST_TO_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && op_o == OP_RELEASE) |=> (unmask_o && !req_o)); // R8

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (req_o && op_o == OP_WIPE_RAM)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9

endmodule

// File: rtl/acx_pin_mask.sv
module acx_pin_mask
    import acx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mask_all_i,
    input  logic                unmask_i,
    input  logic                measured_i,
    input  logic                mon_lock_i,
    input  logic [NUM_PINS-1:0] evt_i,
    output logic [NUM_PINS-1:0] mask_o,
    output logic [NUM_PINS-1:0] pend_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic bit_q;
        logic clr;

        if (p == PIN_INIT) begin : g_init
            assign clr = 1'b1;
        end else if (p == PIN_SMI) begin : g_smi
            assign clr = !measured_i || !mon_lock_i;
        end else begin : g_other
            assign clr = !measured_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                bit_q <= 1'b0;
            else if (mask_all_i)       bit_q <= 1'b1;
            else if (unmask_i && clr)  bit_q <= 1'b0;
        end

        assign mask_o[p] = bit_q;
    end

    assign pend_o = evt_i & ~mask_o;

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_i |=> !mask_o[PIN_INIT]); // R5

    AST_BASIC_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_i && !measured_i) |=> (mask_o == '0)); // R6

    AST_MEASURED_KEEPS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_i && measured_i) |=> (mask_o[PIN_NMI] == $past(mask_o[PIN_NMI])
                                      && mask_o[PIN_A20] == $past(mask_o[PIN_A20]))); // R7

    AST_MEASURED_SMI_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_i && measured_i && mon_lock_i) |=> (mask_o[PIN_SMI] == $past(mask_o[PIN_SMI]))); // R7

endmodule

// File: rtl/acx_exit_ctx.sv
module acx_exit_ctx #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              accept_i,
    input  logic              busy_i,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              measured_i,
    input  logic              mon_i,
    output logic              measured_q_o,
    output logic              mon_q_o,
    output logic              auth_o,
    output logic [ADDR_W-1:0] pc_o
);

    logic [ADDR_W-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q        <= '0;
            measured_q_o <= 1'b0;
            mon_q_o      <= 1'b0;
        end else if (accept_i) begin
            tgt_q        <= target_i;
            measured_q_o <= measured_i;
            mon_q_o      <= mon_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auth_o <= 1'b0;
            pc_o   <= '0;
        end else if (commit_i) begin
            auth_o <= 1'b0;
            pc_o   <= tgt_q;
        end else if (enter_i) begin
            auth_o <= 1'b1;
        end
    end

    AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !commit_i) |=> ($stable(tgt_q) && $stable(measured_q_o) && $stable(mon_q_o))); // R10

    AST_COMMIT_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (!auth_o && pc_o == $past(tgt_q))); // R8

    AST_PC_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(pc_o)); // R8

endmodule

// File: rtl/acx_exit_seq.sv
module acx_exit_seq
    import acx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enter_i,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   target_i,
    input  logic                measured_i,
    input  logic                mon_ctl0_i,
    input  logic                step_ack_i,
    input  logic [NUM_PINS-1:0] pin_evt_i,
    output logic                step_req_o,
    output logic [OP_W-1:0]     step_op_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [NUM_PINS-1:0] pin_mask_o,
    output logic [NUM_PINS-1:0] pin_pend_o,
    output logic                auth_mode_o,
    output logic [ADDR_W-1:0]   pc_o
);

    logic accept, unmask, commit, meas_q, mon_q, enter_ok;

    assign enter_ok = enter_i && !busy_o;

    acx_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .ack_i    (step_ack_i),
        .req_o    (step_req_o),
        .op_o     (step_op_o),
        .busy_o   (busy_o),
        .accept_o (accept),
        .unmask_o (unmask),
        .commit_o (commit),
        .done_o   (done_o)
    );

    acx_exit_ctx #(.ADDR_W(ADDR_W)) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_i      (enter_ok),
        .accept_i     (accept),
        .busy_i       (busy_o),
        .commit_i     (commit),
        .target_i     (target_i),
        .measured_i   (measured_i),
        .mon_i        (mon_ctl0_i),
        .measured_q_o (meas_q),
        .mon_q_o      (mon_q),
        .auth_o       (auth_mode_o),
        .pc_o         (pc_o)
    );

    acx_pin_mask u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_all_i (enter_ok),
        .unmask_i   (unmask),
        .measured_i (meas_q),
        .mon_lock_i (mon_q),
        .evt_i      (pin_evt_i),
        .mask_o     (pin_mask_o),
        .pend_o     (pin_pend_o)
    );

    AST_ENTER_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && enter_i && !unmask) |=> $stable(pin_mask_o)); // R2

    AST_ENTER_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && enter_i) |=> (auth_mode_o && pin_mask_o == '1)); // R2

endmodule

// File: tb/sim_acx_exit_seq.sv
module sim_acx_exit_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_i = 0, start_i = 0, measured_i = 0, mon_ctl0_i = 0, step_ack_i = 0;
    logic [AW-1:0] target_i = '0;
    logic [3:0] pin_evt_i = '0;
    logic step_req_o, busy_o, done_o, auth_mode_o;
    logic [2:0] step_op_o;
    logic [3:0] pin_mask_o, pin_pend_o;
    logic [AW-1:0] pc_o;

    int checks = 0, errors = 0;
    int ack_mode = 0;
    int cyc = 0;
    bit finished = 0;
    int ops_seen[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acx_exit_seq #(.ADDR_W(AW)) u0 (.*);

    // behavioural reference model
    int ph = -1;
    logic [3:0] m_mask = '0;
    logic m_auth = 0, m_done = 0, m_meas = 0, m_mon = 0;
    logic [AW-1:0] m_pc = '0, m_tgt = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = -1; m_mask = '0; m_auth = 0; m_done = 0; m_pc = '0; m_tgt = '0;
            m_meas = 0; m_mon = 0;
        end else begin
            m_done = 0;
            if (ph == -1) begin
                if (enter_i) begin m_auth = 1; m_mask = 4'hF; end
                if (start_i) begin
                    m_tgt = target_i; m_meas = measured_i; m_mon = mon_ctl0_i; ph = 0;
                end
            end else if (ph <= 5) begin
                if (step_ack_i) ph = ph + 1;
            end else if (ph == 6) begin
                m_mask[0] = 0;
                if (!m_meas) m_mask = '0;
                else if (!m_mon) m_mask[1] = 0;
                ph = 7;
            end else begin
                m_auth = 0; m_pc = m_tgt; m_done = 1; ph = -1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic exp_req;
            exp_req = (ph >= 0 && ph <= 5);
            chk(step_req_o == exp_req, "R3/R4", "step_req_o", step_req_o, exp_req);
            if (exp_req) chk(step_op_o == 3'(ph), "R3", "step_op_o", step_op_o, ph);
            chk(busy_o == (ph != -1), "R10", "busy_o", busy_o, ph != -1);
            chk(pin_mask_o == m_mask, "R5/R6/R7", "pin_mask_o", pin_mask_o, m_mask);
            chk(pin_pend_o == (pin_evt_i & ~m_mask), "R11", "pin_pend_o", pin_pend_o, pin_evt_i & ~m_mask);
            chk(auth_mode_o == m_auth, "R8", "auth_mode_o", auth_mode_o, m_auth);
            chk(pc_o == m_pc, "R8", "pc_o", pc_o, m_pc);
            chk(done_o == m_done, "R9", "done_o", done_o, m_done);
            if (step_req_o && step_ack_i) ops_seen.push_back(int'(step_op_o));
        end
    end

    // acknowledge driver
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            case (ack_mode)
                0: step_ack_i = 1'b1;
                1: step_ack_i = (cyc % 3 == 0);
                default: step_ack_i = cyc[0];
            endcase
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done_o) return;
        end
        chk(0, "R9", "done timeout", 0, 1);
    endtask

    task automatic run_exit(input logic [AW-1:0] tgt, input logic meas, input logic mon,
                            input int mode, input bit extra_start,
                            input logic [3:0] exp_mask);
        ack_mode = mode;
        ops_seen.delete();
        tick(); enter_i = 1; tick(); enter_i = 0;
        @(negedge clk);
        chk(auth_mode_o && pin_mask_o == 4'hF, "R2", "enter sets flag and mask",
            {auth_mode_o, pin_mask_o}, 5'h1F);
        tick(); start_i = 1; target_i = tgt; measured_i = meas; mon_ctl0_i = mon;
        tick(); start_i = 0; target_i = ~tgt; measured_i = ~meas; mon_ctl0_i = ~mon;
        if (extra_start) begin
            tick(); tick(); start_i = 1; enter_i = 1; tick(); start_i = 0; enter_i = 0;
        end
        wait_done();
        chk(pc_o == tgt, "R8", "pc after exit", pc_o, tgt);
        chk(!auth_mode_o, "R8", "flag after exit", auth_mode_o, 0);
        chk(pin_mask_o == exp_mask, "R6/R7", "final mask", pin_mask_o, exp_mask);
        chk(!pin_mask_o[0], "R5", "INIT unmasked", pin_mask_o[0], 0);
        chk(ops_seen.size() == 6, "R3", "step count", ops_seen.size(), 6);
        for (int k = 0; k < ops_seen.size(); k++)
            chk(ops_seen[k] == k, "R3", "step order", ops_seen[k], k);
        @(negedge clk);
        chk(!done_o, "R9", "done one cycle", done_o, 0);
        if (extra_start) chk(!busy_o, "R10", "second start ignored", busy_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!step_req_o && !busy_o && !done_o && !auth_mode_o && pc_o == '0 && pin_mask_o == '0,
            "R1", "reset state", {step_req_o, busy_o, done_o, auth_mode_o, pin_mask_o}, 0);
        tick(); rst_n = 1;
        pin_evt_i = 4'hF;
        run_exit(32'h0000_1000, 0, 0, 0, 0, 4'h0);           // R6 basic entry
        chk(pin_pend_o == 4'hF, "R11", "pending visible", pin_pend_o, 4'hF);
        run_exit(32'h0000_2468, 1, 0, 1, 0, 4'hC);           // R7 measured, SMI free
        chk(pin_pend_o == 4'h3, "R11", "pending partial", pin_pend_o, 4'h3);
        run_exit(32'hDEAD_BEEC, 1, 1, 2, 0, 4'hE);           // R7 measured, SMI locked
        pin_evt_i = 4'h5;
        run_exit(32'h0BAD_F00C, 0, 1, 1, 1, 4'h0);           // R10 start while busy, R4 slow ack
        ack_mode = 2;
        repeat (8) tick();
        @(negedge clk);
        chk(!step_req_o && !busy_o, "R4", "idle ack ignored", step_req_o, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule